// File: doc/BRIEF.md
# Asynchronous SRAM Read Sequencer

This block turns a request on an internal request/acknowledge port into one read cycle on an external asynchronous SRAM. Each cycle has three phases: address setup, strobe and hold. Each phase length comes from per-bank configuration fields. During setup only chip select is low. During strobe output enable is low as well. Hold keeps chip select low after output enable has been released. The read data is sampled on the final strobe cycle and handed back with a one-cycle acknowledge.

There are two banks, chosen by the most significant request address bit. Each bank has its own three timing fields. It also has a bit that lets the external ready input add wait states to the strobe, and a bit that makes the block drive the data bus to all ones for one cycle after hold. After that cycle the bus is released to weak pull-ups. The bank's settings are latched when the request is accepted.

The requester raises `req_valid` with a stable `req_addr` and keeps both until `req_ack` is high. To start another read at once it can leave `req_valid` high and present the next address in the acknowledge cycle.

Top module: `sram_rd_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `sram_cs_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0 and `req_ack`=0. While `sram_cs_n` is low, `sram_addr` equals the accepted request address and does not change.
- R2: The setup field (4 bits) gives the setup length directly, 0 to 15 cycles. During setup `sram_cs_n`=0 and `sram_oe_n`=1. A value of 0 makes output enable fall in the first chip-select cycle.
- R3: The strobe field (6 bits) holds N−1 for N = 1 to 64 cycles. While the strobe lasts, `sram_cs_n`=0 and `sram_oe_n`=0.
- R4: The hold field (3 bits) holds N−1 for N = 1 to 8 cycles. During hold `sram_cs_n`=0 and `sram_oe_n`=1.
- R5: When the bank's ready-enable bit is 0, `sram_rdy` has no effect and the strobe lasts exactly its programmed length.
- R6: When the bank's ready-enable bit is 1, `sram_rdy` is examined only after the programmed strobe length has elapsed. The strobe ends on the first such cycle with `sram_rdy`=1. A ready that is high earlier does not shorten the strobe.
- R7: `rd_data` takes the value of `sram_dq_in` from the last strobe cycle and keeps it until the next transfer's capture.
- R8: `req_ack` is high for exactly one cycle, the cycle after the final hold or drive-high cycle. `sram_cs_n`=1 in that cycle.
- R9: With the bank's drive-high bit set, exactly one cycle follows hold with `sram_dq_oe`=1, `sram_dq_out` all ones, `sram_cs_n`=1 and `sram_oe_n`=1. With the bit clear, `sram_dq_oe` stays 0.
- R10: Request address bit AW−1 selects the bank: 0 for bank 0 and 1 for bank 1. Each bank uses only its own fields.
- R11: A request is accepted only when idle. A request held high during a transfer does not disturb it and is taken in the acknowledge cycle, so chip select falls again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request, held until acknowledged |
| req_addr | input | AW | Read address; MSB selects the bank |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| cfg_setup | input | NB*4 | Per-bank setup length, direct |
| cfg_strobe | input | NB*6 | Per-bank strobe length minus one |
| cfg_hold | input | NB*3 | Per-bank hold length minus one |
| cfg_rdy_en | input | NB | Per-bank ready wait-state enable |
| cfg_drive | input | NB | Per-bank drive-high-after-hold enable |
| sram_rdy | input | 1 | External ready, high when data may be taken |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | AW | Address bus |
| sram_dq_in | input | DW | Data bus input |
| sram_dq_out | output | DW | Data bus output value |
| sram_dq_oe | output | 1 | Data bus output enable |

## Verification
A request is accepted at the clock edge after `req_valid` is raised. With S setup cycles, T strobe cycles, W wait states, H hold cycles and D (0 or 1) drive-high cycles, chip select is low for S+T+W+H cycles and `req_ack` is due in cycle S+T+W+H+D+1 after that edge. The bench samples every output at the falling edge of each cycle and counts the phases as they pass. It sets `sram_rdy` from its own strobe-cycle count. It changes the data on the bus in the one cycle that should be captured, so a capture one cycle early or late returns the inverted pattern.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

    parameter int SETUP_W  = 4;
    parameter int STROBE_W = 6;
    parameter int HOLD_W   = 3;

    localparam int CNT_A = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int CNT_W = (STROBE_W > CNT_A) ? STROBE_W : CNT_A;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DRIVE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
        logic                rdy_en;
        logic                drive;
    } bank_cfg_t;

endpackage

// File: rtl/sram_rd_bank_sel.sv
module sram_rd_bank_sel
    import sram_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int NB = 2
) (
    input  logic [AW-1:0]          addr,
    input  logic [NB*SETUP_W-1:0]  cfg_setup,
    input  logic [NB*STROBE_W-1:0] cfg_strobe,
    input  logic [NB*HOLD_W-1:0]   cfg_hold,
    input  logic [NB-1:0]          cfg_rdy_en,
    input  logic [NB-1:0]          cfg_drive,
    output bank_cfg_t              sel
);

    localparam int BSW = (NB > 1) ? $clog2(NB) : 1;

    bank_cfg_t        tbl [NB];
    logic [BSW-1:0]   idx;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign tbl[g].setup  = cfg_setup[g*SETUP_W +: SETUP_W];
        assign tbl[g].strobe = cfg_strobe[g*STROBE_W +: STROBE_W];
        assign tbl[g].hold   = cfg_hold[g*HOLD_W +: HOLD_W];
        assign tbl[g].rdy_en = cfg_rdy_en[g];
        assign tbl[g].drive  = cfg_drive[g];
    end

    if (NB > 1) begin : g_multi
        assign idx = addr[AW-1 -: BSW];
    end else begin : g_single
        assign idx = '0;
    end

    always_comb begin
        sel = tbl[0];
        for (int b = 0; b < NB; b++) begin
            if (idx == BSW'(b)) sel = tbl[b];
        end
    end

endmodule

// File: rtl/sram_rd_fsm.sv
module sram_rd_fsm
    import sram_rd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  bank_cfg_t     cfg_in,
    input  logic          sram_rdy,
    output phase_e        phase,
    output logic [AW-1:0] addr,
    output logic          ack,
    output logic          capture
);

    typedef struct packed {
        phase_e          ph;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        bank_cfg_t        cfg;
        logic             ack;
    } seq_t;

    seq_t seq_d, seq_q;
    logic cap_d;

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = 1'b0;
        cap_d     = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    seq_d.cfg  = cfg_in;
                    if (cfg_in.setup != '0) begin
                        seq_d.ph  = PH_SETUP;
                        seq_d.cnt = CNT_W'(cfg_in.setup) - 1'b1;
                    end else begin
                        seq_d.ph  = PH_STROBE;
                        seq_d.cnt = CNT_W'(cfg_in.strobe);
                    end
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_STROBE;
                    seq_d.cnt = CNT_W'(seq_q.cfg.strobe);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (!seq_q.cfg.rdy_en || sram_rdy) begin
                    cap_d     = 1'b1;
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = CNT_W'(seq_q.cfg.hold);
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (seq_q.cfg.drive) begin
                    seq_d.ph = PH_DRIVE;
                end else begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.ack = 1'b1;
                end
            end
            PH_DRIVE: begin
                seq_d.ph  = PH_IDLE;
                seq_d.ack = 1'b1;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign phase   = seq_q.ph;
    assign addr    = seq_q.addr;
    assign ack     = seq_q.ack;
    assign capture = cap_d;

endmodule

// File: rtl/sram_rd_pins.sv
module sram_rd_pins
    import sram_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic [AW-1:0] addr_in,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic          cs_n,
    output logic          oe_n,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (capture) data_d = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign cs_n     = !(phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
    assign oe_n     = (phase != PH_STROBE);
    assign dq_oe    = (phase == PH_DRIVE);
    assign dq_out   = '1;
    assign addr_out = addr_in;
    assign rd_data  = data_q;

endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
    import sram_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [AW-1:0]          req_addr,
    output logic                   req_ack,
    output logic [DW-1:0]          rd_data,
    input  logic [NB*SETUP_W-1:0]  cfg_setup,
    input  logic [NB*STROBE_W-1:0] cfg_strobe,
    input  logic [NB*HOLD_W-1:0]   cfg_hold,
    input  logic [NB-1:0]          cfg_rdy_en,
    input  logic [NB-1:0]          cfg_drive,
    input  logic                   sram_rdy,
    output logic                   sram_cs_n,
    output logic                   sram_oe_n,
    output logic [AW-1:0]          sram_addr,
    input  logic [DW-1:0]          sram_dq_in,
    output logic [DW-1:0]          sram_dq_out,
    output logic                   sram_dq_oe
);

    bank_cfg_t     bank_cfg;
    phase_e        phase;
    logic [AW-1:0] xfer_addr;
    logic          capture;

    sram_rd_bank_sel #(.AW(AW), .NB(NB)) u_sel (
        .addr       (req_addr),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .cfg_rdy_en (cfg_rdy_en),
        .cfg_drive  (cfg_drive),
        .sel        (bank_cfg)
    );

    sram_rd_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .cfg_in    (bank_cfg),
        .sram_rdy  (sram_rdy),
        .phase     (phase),
        .addr      (xfer_addr),
        .ack       (req_ack),
        .capture   (capture)
    );

    sram_rd_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .addr_in  (xfer_addr),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .cs_n     (sram_cs_n),
        .oe_n     (sram_oe_n),
        .addr_out (sram_addr),
        .dq_out   (sram_dq_out),
        .dq_oe    (sram_dq_oe),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sram_rd_seq_chk.sv
module sram_rd_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ack,
    input logic          sram_cs_n,
    input logic          sram_oe_n,
    input logic [AW-1:0] sram_addr,
    input logic [DW-1:0] sram_dq_out,
    input logic          sram_dq_oe
);

    a_r3_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_cs_n);

    a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    a_r9_drive_ones: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_dq_out == '1 && sram_cs_n && sram_oe_n));

    a_r9_drive_single: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |=> !sram_dq_oe);

    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    a_r8_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (sram_cs_n && !sram_dq_oe));

endmodule

bind sram_rd_seq sram_rd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ack     (req_ack),
    .sram_cs_n   (sram_cs_n),
    .sram_oe_n   (sram_oe_n),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_rd_seq.sv
module test_sram_rd_seq;
    import sram_rd_pkg::*;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NB = 2;
    localparam time CLK_PERIOD = 10ns;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic [AW-1:0]          req_addr = '0;
    logic                   req_ack;
    logic [DW-1:0]          rd_data;
    logic [NB*SETUP_W-1:0]  cfg_setup = '0;
    logic [NB*STROBE_W-1:0] cfg_strobe = '0;
    logic [NB*HOLD_W-1:0]   cfg_hold = '0;
    logic [NB-1:0]          cfg_rdy_en = '0;
    logic [NB-1:0]          cfg_drive = '0;
    logic                   sram_rdy = 1'b0;
    logic                   sram_cs_n;
    logic                   sram_oe_n;
    logic [AW-1:0]          sram_addr;
    logic [DW-1:0]          sram_dq_in = '0;
    logic [DW-1:0]          sram_dq_out;
    logic                   sram_dq_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_rd_seq #(.AW(AW), .DW(DW), .NB(NB)) i_sram_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .rd_data(rd_data), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en),
        .cfg_drive(cfg_drive), .sram_rdy(sram_rdy), .sram_cs_n(sram_cs_n),
        .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_in(sram_dq_in),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return DW'(a) ^ DW'(16'hC3A5);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    task automatic set_bank(input int b, input int s, input int tf, input int hf,
                            input bit en, input bit drv);
        cfg_setup[b*SETUP_W +: SETUP_W]    = SETUP_W'(s);
        cfg_strobe[b*STROBE_W +: STROBE_W] = STROBE_W'(tf);
        cfg_hold[b*HOLD_W +: HOLD_W]       = HOLD_W'(hf);
        cfg_rdy_en[b] = en;
        cfg_drive[b]  = drv;
    endtask

    // rmode: 0 ready low, 1 ready high, 2 ready rises after w wait cycles
    task automatic xfer(input string name, input logic [AW-1:0] a,
                        input int s, input int tf, input int hf, input int w,
                        input int drv, input int rmode, input bit pre_req,
                        input bit chain, input logic [AW-1:0] next_a);
        int lat = 0, csc = 0, oec = 0, prec = 0, dqc = 0;
        bit dq_bad = 0, addr_bad = 0, got = 0;
        logic [DW-1:0] data = '0;
        int t = tf + 1;
        if (!pre_req) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = a;
        end
        sram_rdy = (rmode == 1);
        while (!got && lat < 400) begin
            @(negedge clk);
            lat++;
            if (!sram_cs_n) begin
                csc++;
                if (sram_addr !== a) addr_bad = 1;
            end
            if (!sram_oe_n) oec++;
            else if (!sram_cs_n && oec == 0) prec++;
            if (sram_dq_oe) begin
                dqc++;
                if (sram_dq_out !== '1) dq_bad = 1;
            end
            if (rmode == 2) sram_rdy = !sram_oe_n && (oec >= t + w);
            sram_dq_in = (!sram_oe_n && oec == t + w) ? pat(a) : ~pat(a);
            if (req_ack) begin
                got  = 1;
                data = rd_data;
                if (chain) req_addr = next_a;
                else       req_valid = 1'b0;
            end
        end
        chk({"R2 setup cycles ", name}, prec, s);
        chk({"R3 strobe cycles ", name}, oec, t + w);
        chk({"R4 chip-select cycles ", name}, csc, s + t + w + hf + 1);
        chk({"R1 address held ", name}, addr_bad, 0);
        chk({"R9 drive-high cycles ", name}, dqc, drv);
        chk({"R9 drive value ", name}, dq_bad, 0);
        chk({"R8 ack latency ", name}, lat, s + t + w + hf + 1 + drv + 1);
        chk({"R7 read data ", name}, data, pat(a));
        if (!chain) begin
            @(negedge clk);
            chk({"R8 ack single ", name}, req_ack, 0);
            chk({"R1 idle cs_n ", name}, sram_cs_n, 1);
        end
        sram_rdy = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset cs_n", sram_cs_n, 1);
        chk("R1 reset oe_n", sram_oe_n, 1);
        chk("R1 reset dq_oe", sram_dq_oe, 0);
        chk("R1 reset ack", req_ack, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle no request", sram_cs_n, 1);
    endtask

    task automatic t_basic();
        set_bank(0, 2, 2, 1, 0, 0);
        xfer("basic", 16'h0123, 2, 2, 1, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_setup_zero();
        set_bank(0, 0, 0, 0, 0, 0);
        xfer("minimum", 16'h0040, 0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_ready_ignored();
        set_bank(0, 1, 3, 2, 0, 0);
        xfer("R5 ready disabled", 16'h0777, 1, 3, 2, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_wait_states();
        set_bank(0, 1, 2, 0, 1, 0);
        xfer("R6 four waits", 16'h0A0A, 1, 2, 0, 4, 0, 2, 0, 0, '0);
    endtask

    task automatic t_ready_early();
        set_bank(0, 0, 4, 1, 1, 0);
        xfer("R6 ready early", 16'h0B0B, 0, 4, 1, 0, 0, 1, 0, 0, '0);
    endtask

    task automatic t_drive();
        set_bank(0, 1, 1, 1, 0, 1);
        xfer("R9 drive", 16'h0C0C, 1, 1, 1, 0, 1, 0, 0, 0, '0);
    endtask

    task automatic t_bank1();
        set_bank(0, 7, 9, 5, 1, 1);
        set_bank(1, 3, 1, 2, 0, 0);
        xfer("R10 bank1", 16'h8421, 3, 1, 2, 0, 0, 0, 0, 0, '0);
        xfer("R10 bank0", 16'h0421, 7, 9, 5, 0, 1, 1, 0, 0, '0);
    endtask

    task automatic t_max();
        set_bank(1, 15, 63, 7, 0, 0);
        xfer("maximum", 16'hFFFE, 15, 63, 7, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_back_to_back();
        set_bank(0, 2, 1, 1, 0, 0);
        set_bank(1, 1, 2, 0, 0, 1);
        xfer("R11 first", 16'h0155, 2, 1, 1, 0, 0, 0, 0, 1, 16'h8266);
        xfer("R11 second", 16'h8266, 1, 2, 0, 0, 1, 0, 1, 0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_setup_zero();
        t_ready_ignored();
        t_wait_states();
        t_ready_early();
        t_drive();
        t_bank1();
        t_max();
        t_back_to_back();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule